// File: doc/BRIEF.md
# Dual input logic and deglitch filter

This block conditions a pair of digital inputs, `in_a` and `in_b`, that have already been selected by upstream routing. A 3-bit mode code picks how the two registered outputs are formed. The outputs can carry the inputs as they are. The first output can instead carry a logical combination of the two inputs while the second output carries `in_b`. As a third choice, both outputs can come from a pair of deglitchers that change state only when every stored sample agrees.

The deglitchers have no divider of their own. They take their pace from one of four sample-enable strobes that are shared across the chip. In a filter mode, the low two bits of the mode code pick the strobe. The sample histories and the filtered levels survive a mode change. A channel can therefore leave a filter mode and later return to it without having to settle again.

Top module: `dual_input_conditioner`

## Requirements
- R1: With mode 3'b000, `out_a` equals `in_a` and `out_b` equals `in_b`, each registered once (valid after the next rising clock edge).
- R2: With mode 3'b001, `out_a` is `in_a & in_b` and `out_b` is `in_b`, one clock after the inputs.
- R3: With mode 3'b010, `out_a` is `in_a | in_b` and `out_b` is `in_b`, one clock after the inputs.
- R4: With mode 3'b011, `out_a` is `in_a ^ in_b` and `out_b` is `in_b`, one clock after the inputs.
- R5: In modes 3'b100 to 3'b111, each output shows its channel's filtered level. The filtered level takes a new value only when the three most recent strobed samples all equal that value. The output reflects this two clock edges after the strobe cycle that completed the agreement.
- R6: When the three stored samples of a channel disagree, its filtered level holds its previous value.
- R7: In a filter mode, the sample histories advance only on cycles in which `smp_en[mode[1:0]]` is high. Pulses on the other three strobes have no effect.
- R8: Synchronous active-high reset clears both sample histories, both filtered levels and both outputs to 0.
- R9: A new mode code takes effect at the next rising edge. Changing the mode never clears the sample histories or the filtered levels. In modes 3'b000 to 3'b011 the histories do not advance, whatever the strobes do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_a | input | 1 | First conditioned input |
| in_b | input | 1 | Second conditioned input |
| mode | input | 3 | Mode code: bit 2 selects filtering; bits 1:0 select the logic operation or the strobe |
| smp_en | input | 4 | Shared sample-enable strobes, one per global filter setting |
| out_a | output | 1 | First conditioned output (registered) |
| out_b | output | 1 | Second conditioned output (registered) |

## Verification
The bench targets the boundary of the vote. It checks that two agreeing samples are not enough, which a design that votes on too few samples would get wrong. It checks that an alternating 0-1-0 pattern leaves the level alone, which a majority vote would not. It pulses a strobe that the current mode has not selected and expects no change; a design with a wrong strobe index would respond to that pulse. It partly fills a history, leaves filter mode, pulses a strobe while the block is in a pass mode, and then returns. That sequence exposes a design that clears its history on a mode change, and one that keeps sampling while it is not filtering.

// File: rtl/dual_input_conditioner_pkg.sv
package dual_input_conditioner_pkg;
  // Low two bits of the mode code name the logic operation when bit 2 is clear.
  typedef enum logic [1:0] {
    OP_PASS = 2'b00,
    OP_AND  = 2'b01,
    OP_OR   = 2'b10,
    OP_XOR  = 2'b11
  } logic_op_e;

  localparam int NUM_CH = 2;
endpackage

// File: rtl/dic_logic_combine.sv
module dic_logic_combine
  import dual_input_conditioner_pkg::*;
(
  input  logic [1:0] op,
  input  logic       a,
  input  logic       b,
  output logic       y_a,
  output logic       y_b
);
  always_comb begin
    y_b = b;
    unique case (logic_op_e'(op))
      OP_AND:  y_a = a & b;
      OP_OR:   y_a = a | b;
      OP_XOR:  y_a = a ^ b;
      default: y_a = a;
    endcase
  end
endmodule

// File: rtl/dic_vote_filter.sv
module dic_vote_filter #(
  parameter int DEPTH = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  input  logic din,
  output logic level
);
  logic [DEPTH-1:0] hist;
  logic [DEPTH-1:0] hist_nxt;

  assign hist_nxt = {hist[DEPTH-2:0], din};

  always_ff @(posedge clk) begin
    if (rst) begin
      hist  <= '0;
      level <= 1'b0;
    end else if (adv) begin
      hist <= hist_nxt;
      if (&hist_nxt)       level <= 1'b1;
      else if (~|hist_nxt) level <= 1'b0;
    end
  end

  // History is frozen on cycles without a selected strobe.
  assert_hist_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(hist));
  // A rise needs a unanimous history of ones.
  assert_rise_unanimous_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(level) |-> (&hist));
  // A fall needs a unanimous history of zeros.
  assert_fall_unanimous_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(level) |-> (~|hist));
  // Mixed history never coincides with a level change.
  assert_mixed_holds_R6: assert property (@(posedge clk) disable iff (rst)
    ((|hist) && !(&hist)) |-> $stable(level));
endmodule

// File: rtl/dual_input_conditioner.sv
module dual_input_conditioner
  import dual_input_conditioner_pkg::*;
#(
  parameter int NUM_STROBES = 4,
  parameter int VOTE_DEPTH  = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_a,
  input  logic                    in_b,
  input  logic [2:0]              mode,
  input  logic [NUM_STROBES-1:0]  smp_en,
  output logic                    out_a,
  output logic                    out_b
);
  localparam int SEL_W = $clog2(NUM_STROBES);

  logic              filt_mode;
  logic              adv;
  logic [NUM_CH-1:0] ch_in;
  logic [NUM_CH-1:0] ch_lvl;
  logic              comb_a;
  logic              comb_b;

  assign filt_mode = mode[2];
  assign adv       = filt_mode & smp_en[mode[SEL_W-1:0]];
  assign ch_in     = {in_b, in_a};

  dic_logic_combine u_combine (
    .op  (mode[1:0]),
    .a   (in_a),
    .b   (in_b),
    .y_a (comb_a),
    .y_b (comb_b)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_vote
    dic_vote_filter #(.DEPTH(VOTE_DEPTH)) u_vote (
      .clk   (clk),
      .rst   (rst),
      .adv   (adv),
      .din   (ch_in[ch]),
      .level (ch_lvl[ch])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_a <= 1'b0;
      out_b <= 1'b0;
    end else if (filt_mode) begin
      out_a <= ch_lvl[0];
      out_b <= ch_lvl[1];
    end else begin
      out_a <= comb_a;
      out_b <= comb_b;
    end
  end

  // Second output follows in_b one clock later in every non-filter mode.
  assert_b_pass_R2: assert property (@(posedge clk) disable iff (rst)
    !mode[2] |=> (out_b == $past(in_b)));
  // In a filter mode the outputs carry the filtered levels one clock later.
  assert_filt_route_R5: assert property (@(posedge clk) disable iff (rst)
    mode[2] |=> (out_a == $past(ch_lvl[0]) && out_b == $past(ch_lvl[1])));
  // Filtered levels do not move in pass and logic modes.
  assert_no_filter_adv_R9: assert property (@(posedge clk) disable iff (rst)
    !mode[2] |=> $stable(ch_lvl));
  // Reset leaves the outputs low.
  assert_reset_low_R8: assert property (@(posedge clk)
    rst |=> (!out_a && !out_b));
endmodule

// File: tb/test_dual_input_conditioner.sv
module test_dual_input_conditioner;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 16;
  // {mode[2:0], a, b, exp_a, exp_b}
  localparam logic [6:0] VEC [NVEC] = '{
    7'b000_00_00, 7'b000_01_01, 7'b000_10_10, 7'b000_11_11,   // R1
    7'b001_00_00, 7'b001_01_01, 7'b001_10_00, 7'b001_11_11,   // R2
    7'b010_00_00, 7'b010_01_11, 7'b010_10_10, 7'b010_11_11,   // R3
    7'b011_00_00, 7'b011_01_11, 7'b011_10_10, 7'b011_11_01    // R4
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_a = 1'b0, in_b = 1'b0;
  logic [2:0] mode = 3'b000;
  logic [3:0] smp_en = 4'b0000;
  logic       out_a, out_b;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_input_conditioner i_dual_input_conditioner (
    .clk(clk), .rst(rst), .in_a(in_a), .in_b(in_b),
    .mode(mode), .smp_en(smp_en), .out_a(out_a), .out_b(out_b)
  );

  task automatic check(input string req, input logic ea, input logic eb);
    n_chk++;
    if (out_a !== ea || out_b !== eb) begin
      n_bad++;
      $display("FAIL %s: got a=%b b=%b, expected a=%b b=%b", req, out_a, out_b, ea, eb);
    end
  endtask

  task automatic pulse(input int idx);
    smp_en[idx] = 1'b1;
    @(negedge clk);
    smp_en[idx] = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R8", 1'b0, 1'b0);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      mode = VEC[i][6:4]; in_a = VEC[i][3]; in_b = VEC[i][2];
      @(negedge clk);
      check($sformatf("R%0d vec%0d", 1 + VEC[i][5:4], i), VEC[i][1], VEC[i][0]);
    end

    // R5: two agreeing samples are not enough, the third is.
    mode = 3'b100; in_a = 1'b1; in_b = 1'b1;
    pulse(0); pulse(0); @(negedge clk);
    check("R5 two samples", 1'b0, 1'b0);
    pulse(0); @(negedge clk);
    check("R5 three samples", 1'b1, 1'b1);

    // R6: alternating samples hold the level.
    in_a = 1'b0; pulse(0);
    in_a = 1'b1; pulse(0);
    in_a = 1'b0; pulse(0); @(negedge clk);
    check("R6 mixed hold", 1'b1, 1'b1);

    // R7: mode 101 listens to strobe 1 only.
    mode = 3'b101; in_a = 1'b0;
    pulse(0); pulse(2); pulse(3); @(negedge clk);
    check("R7 wrong strobe", 1'b1, 1'b1);
    pulse(1); pulse(1); pulse(1); @(negedge clk);
    check("R7 right strobe", 1'b0, 1'b1);

    // R9: partial history survives a mode change and is frozen in pass mode.
    mode = 3'b100; in_a = 1'b1;
    pulse(0); pulse(0);
    mode = 3'b000; in_a = 1'b0;
    @(negedge clk);
    check("R9 pass next clock", 1'b0, 1'b1);
    pulse(0); pulse(0);
    mode = 3'b100; in_a = 1'b1;
    pulse(0); @(negedge clk);
    check("R9 history kept", 1'b1, 1'b1);

    // R8: reset mid-run clears everything.
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    check("R8 rerun", 1'b0, 1'b0);
    in_a = 1'b1; pulse(0); @(negedge clk);
    check("R8 history cleared", 1'b0, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule